// File: doc/BRIEF.md
# Eight-Line Interrupt Controller Command Sequencer

This block is the register front end of an eight-input priority interrupt controller. It sits on a byte-wide chip-select/write/read bus with one address bit. It turns the writes it sees into configuration and commands, and it answers reads with controller state. A write at address 0 with data bit 4 set starts a multi-word setup sequence. The follow-up words arrive at address 1 and load the vector base and the optional mode word. Outside setup, address-0 writes are either mode commands or opcode-coded end-of-interrupt and priority-rotation commands. Address-1 writes load the mask.

The block owns the mask, the vector base, the mode flags, the rotation offset and the in-service register. The pending register and the current winning line come in from the neighbouring request logic and priority resolver. An acknowledge input marks a line as in service. In poll mode the next read returns the winning line and retires it, and a one-hot clear strobe tells the request logic to drop that pending bit. The single-mode and level-trigger bits of the first setup word are accepted and have no effect.

Top module: `pic_cmd_seq`

## Requirements
- R1: Reset leaves the sequencer in normal operation with mask, in-service register, vector base, rotation offset and all mode flags at zero.
- R2: An address-0 write with data bit 4 set enters setup (busy) and clears the mask, rotation offset, special mask and read select.
- R3: In that first setup word, bit 0 requests a fourth word. When bit 0 is clear, auto-EOI and special-nested are cleared at once. When it is set, both flags keep their values.
- R4: During setup, address-1 writes are taken in order: first the vector base from data[7:3], then a cascade word that is discarded, then (only if requested) a mode word with special-nested from bit 4 and auto-EOI from bit 1. None of these writes changes the mask.
- R5: An address-1 write outside setup loads the mask register.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. Bit 1 set loads read select from bit 0. Bit 6 set loads special mask from bit 5. A cleared enable bit leaves its field unchanged.
- R7: For other address-0 writes, data[7:5] is an opcode. Opcode 0 clears rotate-on-auto-EOI and opcode 4 sets it. Opcode 2 changes nothing.
- R8: Opcode 1 clears the highest-priority in-service bit. Priority starts at the line equal to the rotation offset and rises modulo 8. With the in-service register empty, nothing changes.
- R9: Opcode 5 clears the same bit as opcode 1 and sets the rotation offset to that line plus 1, modulo 8.
- R10: Opcode 3 clears in-service bit data[2:0]. Opcode 7 does the same and also sets the offset to data[2:0] plus 1, modulo 8.
- R11: Opcode 6 sets the rotation offset to data[2:0] plus 1, modulo 8, and touches no in-service bit.
- R12: A read at address 0 returns the in-service register when read select is 1 and the pending input otherwise. A read at address 1 returns the mask. The data output is zero when no read is active.
- R13: With poll armed, the next read at either address returns the winning line number, clears that line's in-service bit and pulses the one-hot pending-clear output for it. With no winner, the read returns 7. Either way poll is disarmed.
- R14: An acknowledge sets the acknowledged line's in-service bit unless auto-EOI is on. With auto-EOI on, the bit stays clear, and if rotate-on-auto-EOI is set the offset becomes that line plus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select for the register port |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| a0_i | input | 1 | Register address bit |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Read data, valid during the read cycle |
| irr_i | input | 8 | Pending register from the request logic |
| win_vld_i | input | 1 | Priority resolver has a qualifying line |
| win_line_i | input | 3 | Winning line number from the resolver |
| ack_vld_i | input | 1 | Interrupt acknowledge for one line |
| ack_line_i | input | 3 | Line being acknowledged |
| imr_o | output | 8 | Mask register |
| isr_o | output | 8 | In-service register |
| vec_base_o | output | 5 | Vector base (upper five vector bits) |
| rot_ofs_o | output | 3 | Rotation offset: line with top priority |
| aeoi_o | output | 1 | Auto-EOI mode flag |
| sfnm_o | output | 1 | Special-nested mode flag |
| smask_o | output | 1 | Special mask mode flag |
| rot_aeoi_o | output | 1 | Rotate-on-auto-EOI flag |
| init_busy_o | output | 1 | Setup sequence in progress |
| pend_clr_o | output | 8 | One-hot pending-bit clear, during a poll read |

## Verification
A wrong setup state shows up as a lost mask write, or as a vector base or mode word landing in the wrong field. The bench sees this on the first address-1 read after the sequence. A wrong rotation offset is silent until the next non-specific EOI, which then retires the wrong in-service bit. Reading the in-service register one cycle later exposes it. Poll errors appear within the read cycle itself, as a wrong line number or pending-clear strobe, and a failure to disarm shows on the very next read.

// File: rtl/pic_seq_pkg.sv
`timescale 1ns/1ps
package pic_seq_pkg;

   // Setup sequencer states
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_BASE = 2'd1,
      ST_CASC = 2'd2,
      ST_MODE = 2'd3
   } seq_st_e;

   // Command opcode held in data[7:5]
   typedef enum logic [2:0] {
      OP_RAEOI_OFF = 3'd0,
      OP_EOI       = 3'd1,
      OP_NOP       = 3'd2,
      OP_SEOI      = 3'd3,
      OP_RAEOI_ON  = 3'd4,
      OP_REOI      = 3'd5,
      OP_SETPRI    = 3'd6,
      OP_RSEOI     = 3'd7
   } cmd_op_e;

   // Bit positions the decoder depends on
   localparam int B_INIT     = 4;
   localparam int B_MODECMD  = 3;
   localparam int B_NEED4    = 0;
   localparam int B_POLL     = 2;
   localparam int B_RSEL_EN  = 1;
   localparam int B_RSEL     = 0;
   localparam int B_SMM_EN   = 6;
   localparam int B_SMM      = 5;
   localparam int B_SFNM     = 4;
   localparam int B_AEOI     = 1;
   localparam int OP_LSB     = 5;

endpackage

// File: rtl/pic_seq_init_fsm.sv
`timescale 1ns/1ps
module pic_seq_init_fsm
   import pic_seq_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DW     = 8,
   localparam int IDW    = $clog2(LINES),
   localparam int BASE_W = DW - IDW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dat_wr_i,
   input  logic              need4_i,
   input  logic [BASE_W-1:0] base_i,
   input  logic              sfnm_i,
   input  logic              aeoi_i,
   output logic              busy_o,
   output logic              run_wr_o,
   output logic [BASE_W-1:0] base_o,
   output logic              sfnm_o,
   output logic              aeoi_o
);

   seq_st_e st_q;
   logic    need4_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         need4_q <= 1'b0;
         base_o  <= '0;
         sfnm_o  <= 1'b0;
         aeoi_o  <= 1'b0;
      end else if (start_i) begin
         st_q    <= ST_BASE;
         need4_q <= need4_i;
         if (!need4_i) begin
            sfnm_o <= 1'b0;
            aeoi_o <= 1'b0;
         end
      end else if (dat_wr_i) begin
         case (st_q)
            ST_BASE: begin
               base_o <= base_i;
               st_q   <= ST_CASC;
            end
            ST_CASC: st_q <= need4_q ? ST_MODE : ST_RUN;
            ST_MODE: begin
               sfnm_o <= sfnm_i;
               aeoi_o <= aeoi_i;
               st_q   <= ST_RUN;
            end
            default: ;
         endcase
      end
   end

   assign busy_o   = (st_q != ST_RUN);
   assign run_wr_o = dat_wr_i && (st_q == ST_RUN);

endmodule

// File: rtl/pic_seq_isr.sv
`timescale 1ns/1ps
module pic_seq_isr #(
   parameter int LINES = 8,
   localparam int IDW  = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] set_i,
   input  logic [LINES-1:0] clr_i,
   input  logic [IDW-1:0]   ofs_i,
   output logic [LINES-1:0] isr_o,
   output logic             top_vld_o,
   output logic [IDW-1:0]   top_line_o
);

   logic [LINES-1:0] rot;
   logic [IDW-1:0]   idx;

   for (genvar g = 0; g < LINES; g++) begin : g_bit
      localparam logic [IDW-1:0] GI = IDW'(g);
      // set beats clear: a fresh acknowledge stays in service
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) isr_o[g] <= 1'b0;
         else        isr_o[g] <= set_i[g] | (isr_o[g] & ~clr_i[g]);
      end
      // priority view: position 0 is the line at the rotation offset
      assign rot[g] = isr_o[GI + ofs_i];
   end

   always_comb begin
      idx = '0;
      for (int k = LINES - 1; k >= 0; k--) begin
         if (rot[k]) idx = IDW'(k);
      end
   end

   assign top_vld_o  = |isr_o;
   assign top_line_o = idx + ofs_i;

endmodule

// File: rtl/pic_seq_rdmux.sv
`timescale 1ns/1ps
module pic_seq_rdmux #(
   parameter int LINES = 8,
   parameter int DW    = 8,
   localparam int IDW  = $clog2(LINES)
) (
   input  logic             re_i,
   input  logic             a0_i,
   input  logic             rsel_i,
   input  logic             poll_i,
   input  logic [LINES-1:0] irr_i,
   input  logic [LINES-1:0] isr_i,
   input  logic [LINES-1:0] imr_i,
   input  logic             win_vld_i,
   input  logic [IDW-1:0]   win_line_i,
   output logic [DW-1:0]    dout_o
);

   logic [DW-1:0] poll_val;
   logic [DW-1:0] reg_val;

   assign poll_val = win_vld_i ? DW'(win_line_i) : DW'(LINES - 1);

   always_comb begin
      if (a0_i)        reg_val = DW'(imr_i);
      else if (rsel_i) reg_val = DW'(isr_i);
      else             reg_val = DW'(irr_i);
   end

   always_comb begin
      if (!re_i)       dout_o = '0;
      else if (poll_i) dout_o = poll_val;
      else             dout_o = reg_val;
   end

endmodule

// File: rtl/pic_cmd_seq.sv
`timescale 1ns/1ps
module pic_cmd_seq
   import pic_seq_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DW     = 8,
   localparam int IDW    = $clog2(LINES),
   localparam int BASE_W = DW - IDW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic              a0_i,
   input  logic [DW-1:0]     din_i,
   output logic [DW-1:0]     dout_o,
   input  logic [LINES-1:0]  irr_i,
   input  logic              win_vld_i,
   input  logic [IDW-1:0]    win_line_i,
   input  logic              ack_vld_i,
   input  logic [IDW-1:0]    ack_line_i,
   output logic [LINES-1:0]  imr_o,
   output logic [LINES-1:0]  isr_o,
   output logic [BASE_W-1:0] vec_base_o,
   output logic [IDW-1:0]    rot_ofs_o,
   output logic              aeoi_o,
   output logic              sfnm_o,
   output logic              smask_o,
   output logic              rot_aeoi_o,
   output logic              init_busy_o,
   output logic [LINES-1:0]  pend_clr_o
);

   // Elaboration checks: command fields are fixed byte positions
   if (DW != 8) begin : g_bad_dw
      $error("pic_cmd_seq: DW must be 8");
   end
   if (LINES < 2 || LINES > 8 || LINES != (1 << IDW)) begin : g_bad_lines
      $error("pic_cmd_seq: LINES must be 2, 4 or 8");
   end

   // ---------------- bus decode ----------------
   logic    we, re;
   logic    wr_cmd, init_w, mode_w, op_w, dat_w;
   cmd_op_e op;
   logic [IDW-1:0] lin;

   assign we     = cs_i & wr_i;
   assign re     = cs_i & rd_i;
   assign wr_cmd = we & ~a0_i;
   assign dat_w  = we & a0_i;
   assign init_w = wr_cmd &  din_i[B_INIT];
   assign mode_w = wr_cmd & ~din_i[B_INIT] &  din_i[B_MODECMD];
   assign op_w   = wr_cmd & ~din_i[B_INIT] & ~din_i[B_MODECMD];
   assign op     = cmd_op_e'(din_i[OP_LSB +: 3]);
   assign lin    = din_i[IDW-1:0];

   // ---------------- setup sequence ----------------
   logic run_wr;

   pic_seq_init_fsm #(.LINES(LINES), .DW(DW)) u_init (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (init_w),
      .dat_wr_i (dat_w),
      .need4_i  (din_i[B_NEED4]),
      .base_i   (din_i[DW-1:IDW]),
      .sfnm_i   (din_i[B_SFNM]),
      .aeoi_i   (din_i[B_AEOI]),
      .busy_o   (init_busy_o),
      .run_wr_o (run_wr),
      .base_o   (vec_base_o),
      .sfnm_o   (sfnm_o),
      .aeoi_o   (aeoi_o)
   );

   // ---------------- in-service register ----------------
   logic [LINES-1:0] isr_set, isr_clr;
   logic             top_vld;
   logic [IDW-1:0]   top_line;
   logic [IDW-1:0]   ofs_q, ofs_d;

   pic_seq_isr #(.LINES(LINES)) u_isr (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (isr_set),
      .clr_i      (isr_clr),
      .ofs_i      (ofs_q),
      .isr_o      (isr_o),
      .top_vld_o  (top_vld),
      .top_line_o (top_line)
   );

   // ---------------- mode registers ----------------
   logic [LINES-1:0] imr_q;
   logic             rsel_q, smask_q, poll_q, rot_aeoi_q;
   logic             poll_hit;

   assign poll_hit = re & poll_q & win_vld_i;

   always_comb begin
      isr_set = '0;
      if (ack_vld_i && !aeoi_o) isr_set = LINES'(1) << ack_line_i;
   end

   always_comb begin
      isr_clr = '0;
      if (op_w) begin
         case (op)
            OP_EOI, OP_REOI:  if (top_vld) isr_clr = LINES'(1) << top_line;
            OP_SEOI, OP_RSEOI: isr_clr = LINES'(1) << lin;
            default: ;
         endcase
      end
      if (poll_hit) isr_clr = isr_clr | (LINES'(1) << win_line_i);
   end

   always_comb begin
      ofs_d = ofs_q;
      if (ack_vld_i && aeoi_o && rot_aeoi_q) ofs_d = ack_line_i + IDW'(1);
      if (init_w) begin
         ofs_d = '0;
      end else if (op_w) begin
         case (op)
            OP_REOI:            if (top_vld) ofs_d = top_line + IDW'(1);
            OP_SETPRI, OP_RSEOI: ofs_d = lin + IDW'(1);
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q      <= '0;
         imr_q      <= '0;
         rsel_q     <= 1'b0;
         smask_q    <= 1'b0;
         poll_q     <= 1'b0;
         rot_aeoi_q <= 1'b0;
      end else begin
         ofs_q <= ofs_d;
         if (init_w) begin
            imr_q   <= '0;
            rsel_q  <= 1'b0;
            smask_q <= 1'b0;
         end else if (run_wr) begin
            imr_q <= din_i[LINES-1:0];
         end else if (mode_w) begin
            if (din_i[B_RSEL_EN]) rsel_q  <= din_i[B_RSEL];
            if (din_i[B_SMM_EN])  smask_q <= din_i[B_SMM];
         end
         if (mode_w && din_i[B_POLL]) poll_q <= 1'b1;
         else if (re)                 poll_q <= 1'b0;
         if (op_w && (op == OP_RAEOI_OFF || op == OP_RAEOI_ON))
            rot_aeoi_q <= din_i[OP_LSB + 2];
      end
   end

   // ---------------- read path ----------------
   pic_seq_rdmux #(.LINES(LINES), .DW(DW)) u_rd (
      .re_i       (re),
      .a0_i       (a0_i),
      .rsel_i     (rsel_q),
      .poll_i     (poll_q),
      .irr_i      (irr_i),
      .isr_i      (isr_o),
      .imr_i      (imr_q),
      .win_vld_i  (win_vld_i),
      .win_line_i (win_line_i),
      .dout_o     (dout_o)
   );

   assign pend_clr_o = poll_hit ? (LINES'(1) << win_line_i) : '0;
   assign imr_o      = imr_q;
   assign rot_ofs_o  = ofs_q;
   assign smask_o    = smask_q;
   assign rot_aeoi_o = rot_aeoi_q;

endmodule

// File: rtl/pic_cmd_seq_chk.sv
`timescale 1ns/1ps
module pic_cmd_seq_chk #(
   parameter int LINES = 8,
   parameter int DW    = 8,
   localparam int IDW  = $clog2(LINES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_i,
   input logic             wr_i,
   input logic             rd_i,
   input logic             a0_i,
   input logic [DW-1:0]    din_i,
   input logic [DW-1:0]    dout_o,
   input logic             ack_vld_i,
   input logic [IDW-1:0]   ack_line_i,
   input logic [LINES-1:0] imr_o,
   input logic [LINES-1:0] isr_o,
   input logic [IDW-1:0]   rot_ofs_o,
   input logic             aeoi_o,
   input logic             smask_o,
   input logic             init_busy_o,
   input logic [LINES-1:0] pend_clr_o
);

   a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && wr_i && !a0_i && din_i[4]) |=>
         (imr_o == '0 && rot_ofs_o == '0 && !smask_o && init_busy_o));

   a_r4_setup_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (init_busy_o && !(cs_i && wr_i)) |=> init_busy_o);

   a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && wr_i && a0_i && !init_busy_o) |=> (imr_o == $past(din_i[LINES-1:0])));

   a_r8_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && wr_i && !rd_i && !a0_i && din_i[7:3] == 5'b00100 && !ack_vld_i) |=>
         (($past(isr_o) == '0) ? (isr_o == '0)
                               : ($countones(isr_o) + 1 == $countones($past(isr_o)))));

   a_r12_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs_i && rd_i) |-> (dout_o == '0));

   a_r13_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pend_clr_o));

   a_r13_clr_matches_line: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr_o != '0) |-> (cs_i && rd_i && pend_clr_o[dout_o[IDW-1:0]]));

   a_r14_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld_i && !aeoi_o && !(cs_i && (wr_i || rd_i))) |=> isr_o[$past(ack_line_i)]);

endmodule

bind pic_cmd_seq pic_cmd_seq_chk #(.LINES(LINES), .DW(DW)) u_chk (.*);

// File: tb/pic_cmd_seq_bench.sv
`timescale 1ns/1ps
module pic_cmd_seq_bench;

   localparam int CLK_NS = 10;
   localparam int NV     = 34;
   // entry: {req[3:0], kind[1:0], a0, data[7:0], irr[7:0], exp[7:0]}
   // kind 0 = write, 1 = read and compare, 2 = acknowledge line data[2:0]
   localparam logic [30:0] TBL [NV] = '{
      {4'd2,  2'd0, 1'b0, 8'h11, 8'h00, 8'h00}, // R2 setup, fourth word wanted
      {4'd4,  2'd0, 1'b1, 8'h48, 8'h00, 8'h00}, // R4 base = 9
      {4'd4,  2'd0, 1'b1, 8'h00, 8'h00, 8'h00}, // R4 cascade word
      {4'd4,  2'd0, 1'b1, 8'h10, 8'h00, 8'h00}, // R4 mode word
      {4'd5,  2'd0, 1'b1, 8'hF0, 8'h00, 8'h00}, // R5 mask
      {4'd5,  2'd1, 1'b1, 8'h00, 8'h00, 8'hF0},
      {4'd12, 2'd1, 1'b0, 8'h00, 8'h5A, 8'h5A}, // R12 pending view
      {4'd14, 2'd2, 1'b0, 8'h03, 8'h00, 8'h00},
      {4'd14, 2'd2, 1'b0, 8'h06, 8'h00, 8'h00},
      {4'd14, 2'd2, 1'b0, 8'h01, 8'h00, 8'h00},
      {4'd6,  2'd0, 1'b0, 8'h0B, 8'h00, 8'h00}, // R6 read select = 1
      {4'd12, 2'd1, 1'b0, 8'h00, 8'h5A, 8'h4A}, // R12 in-service view
      {4'd8,  2'd0, 1'b0, 8'h20, 8'h00, 8'h00}, // R8 clears line 1
      {4'd8,  2'd1, 1'b0, 8'h00, 8'h00, 8'h48},
      {4'd9,  2'd0, 1'b0, 8'hA0, 8'h00, 8'h00}, // R9 clears 3, offset 4
      {4'd9,  2'd1, 1'b0, 8'h00, 8'h00, 8'h40},
      {4'd14, 2'd2, 1'b0, 8'h02, 8'h00, 8'h00},
      {4'd14, 2'd2, 1'b0, 8'h05, 8'h00, 8'h00},
      {4'd9,  2'd0, 1'b0, 8'h20, 8'h00, 8'h00}, // R9 offset 4: line 5 first
      {4'd9,  2'd1, 1'b0, 8'h00, 8'h00, 8'h44},
      {4'd10, 2'd0, 1'b0, 8'h66, 8'h00, 8'h00}, // R10 specific line 6
      {4'd10, 2'd1, 1'b0, 8'h00, 8'h00, 8'h04},
      {4'd10, 2'd0, 1'b0, 8'hE2, 8'h00, 8'h00}, // R10 line 2, offset 3
      {4'd10, 2'd1, 1'b0, 8'h00, 8'h00, 8'h00},
      {4'd8,  2'd0, 1'b0, 8'h20, 8'h00, 8'h00}, // R8 empty register
      {4'd8,  2'd1, 1'b0, 8'h00, 8'h00, 8'h00},
      {4'd6,  2'd0, 1'b0, 8'h0A, 8'h00, 8'h00}, // R6 read select = 0
      {4'd6,  2'd1, 1'b0, 8'h00, 8'h81, 8'h81},
      {4'd3,  2'd0, 1'b0, 8'h10, 8'h00, 8'h00}, // R3 setup, no fourth word
      {4'd4,  2'd0, 1'b1, 8'h33, 8'h00, 8'h00}, // R4 base = 6, not mask
      {4'd4,  2'd0, 1'b1, 8'hFF, 8'h00, 8'h00},
      {4'd4,  2'd1, 1'b1, 8'h00, 8'h00, 8'h00}, // R4 mask untouched
      {4'd5,  2'd0, 1'b1, 8'h3C, 8'h00, 8'h00},
      {4'd5,  2'd1, 1'b1, 8'h00, 8'h00, 8'h3C}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, a0_i = 1'b0;
   logic [7:0] din_i = '0;
   logic [7:0] dout_o;
   logic [7:0] irr_i = '0;
   logic       win_vld_i = 1'b0;
   logic [2:0] win_line_i = '0;
   logic       ack_vld_i = 1'b0;
   logic [2:0] ack_line_i = '0;
   logic [7:0] imr_o, isr_o, pend_clr_o;
   logic [4:0] vec_base_o;
   logic [2:0] rot_ofs_o;
   logic       aeoi_o, sfnm_o, smask_o, rot_aeoi_o, init_busy_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [30:0] e;
   logic [7:0]  rdv, pcv;

   always #(CLK_NS / 2) clk = ~clk;

   pic_cmd_seq u_pic_cmd_seq (
      .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .wr_i(wr_i), .rd_i(rd_i), .a0_i(a0_i),
      .din_i(din_i), .dout_o(dout_o), .irr_i(irr_i), .win_vld_i(win_vld_i),
      .win_line_i(win_line_i), .ack_vld_i(ack_vld_i), .ack_line_i(ack_line_i),
      .imr_o(imr_o), .isr_o(isr_o), .vec_base_o(vec_base_o), .rot_ofs_o(rot_ofs_o),
      .aeoi_o(aeoi_o), .sfnm_o(sfnm_o), .smask_o(smask_o), .rot_aeoi_o(rot_aeoi_o),
      .init_busy_o(init_busy_o), .pend_clr_o(pend_clr_o)
   );

   task automatic chk(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic do_wr(input logic a, input logic [7:0] d);
      @(negedge clk); cs_i = 1'b1; wr_i = 1'b1; a0_i = a; din_i = d;
      @(negedge clk); cs_i = 1'b0; wr_i = 1'b0; din_i = '0;
      #1;
   endtask

   task automatic do_rd(input logic a, input logic [7:0] irr, input logic wv,
                        input logic [2:0] wl, output logic [7:0] d, output logic [7:0] pc);
      @(negedge clk); cs_i = 1'b1; rd_i = 1'b1; a0_i = a; irr_i = irr;
      win_vld_i = wv; win_line_i = wl;
      #1; d = dout_o; pc = pend_clr_o;
      @(negedge clk); cs_i = 1'b0; rd_i = 1'b0; win_vld_i = 1'b0;
      #1;
   endtask

   task automatic do_ack(input logic [2:0] l);
      @(negedge clk); ack_vld_i = 1'b1; ack_line_i = l;
      @(negedge clk); ack_vld_i = 1'b0;
      #1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: reset state
      chk(1, "mask", imr_o, 8'h00);
      chk(1, "in-service", isr_o, 8'h00);
      chk(1, "base", {3'b0, vec_base_o}, 8'h00);
      chk(1, "offset", {5'b0, rot_ofs_o}, 8'h00);
      chk(1, "flags", {3'b0, aeoi_o, sfnm_o, smask_o, rot_aeoi_o, init_busy_o}, 8'h00);
      chk(12, "idle data", dout_o, 8'h00);

      for (int i = 0; i < NV; i++) begin
         e = TBL[i];
         case (e[26:25])
            2'd0: do_wr(e[24], e[23:16]);
            2'd1: begin
               do_rd(e[24], e[15:8], 1'b0, 3'd0, rdv, pcv);
               chk(int'(e[30:27]), "table read", rdv, e[7:0]);
            end
            default: do_ack(e[18:16]);
         endcase
      end
      // R2 R3 R4: after the table's last setup
      chk(4, "base after setup", {3'b0, vec_base_o}, 8'h06);
      chk(3, "special-nested cleared", {7'b0, sfnm_o}, 8'h00);
      chk(2, "offset cleared", {5'b0, rot_ofs_o}, 8'h00);
      chk(4, "setup done", {7'b0, init_busy_o}, 8'h00);

      // R11: set-priority wraps modulo 8
      do_wr(1'b0, 8'hC7);
      chk(11, "offset 7+1", {5'b0, rot_ofs_o}, 8'h00);
      do_wr(1'b0, 8'hC3);
      chk(11, "offset 3+1", {5'b0, rot_ofs_o}, 8'h04);

      // R7: rotate-on-auto-EOI flag, and opcode 2 leaves state alone
      do_wr(1'b0, 8'h80);
      chk(7, "rotate-aeoi on", {7'b0, rot_aeoi_o}, 8'h01);
      do_wr(1'b0, 8'h40);
      chk(7, "nop flag", {7'b0, rot_aeoi_o}, 8'h01);
      chk(7, "nop offset", {5'b0, rot_ofs_o}, 8'h04);
      chk(7, "nop mask", imr_o, 8'h3C);
      do_wr(1'b0, 8'h00);
      chk(7, "rotate-aeoi off", {7'b0, rot_aeoi_o}, 8'h00);

      // R3 R4 R14: auto-EOI setup, acknowledge with rotation
      do_wr(1'b0, 8'h11); do_wr(1'b1, 8'h08); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h02);
      chk(4, "auto-EOI from mode word", {7'b0, aeoi_o}, 8'h01);
      do_wr(1'b0, 8'h80);
      do_ack(3'd5);
      chk(14, "auto-EOI keeps bit clear", isr_o, 8'h00);
      chk(14, "auto-EOI rotation", {5'b0, rot_ofs_o}, 8'h06);
      do_wr(1'b0, 8'h11);
      chk(3, "flag kept when fourth word due", {7'b0, aeoi_o}, 8'h01);
      chk(2, "busy", {7'b0, init_busy_o}, 8'h01);
      do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h02);
      do_wr(1'b0, 8'h10);
      chk(3, "flag cleared without fourth word", {7'b0, aeoi_o}, 8'h00);
      do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00);
      chk(4, "setup ends after cascade", {7'b0, init_busy_o}, 8'h00);

      // R14 normal acknowledge, R13 poll
      do_ack(3'd2);
      chk(14, "ack sets bit", isr_o, 8'h04);
      do_wr(1'b1, 8'h55);
      do_wr(1'b0, 8'h0C);
      do_rd(1'b1, 8'h04, 1'b1, 3'd2, rdv, pcv);
      chk(13, "poll line", rdv, 8'h02);
      chk(13, "poll pending clear", pcv, 8'h04);
      chk(13, "poll retires in-service", isr_o, 8'h00);
      do_rd(1'b1, 8'h00, 1'b1, 3'd2, rdv, pcv);
      chk(13, "poll disarmed", rdv, 8'h55);
      chk(13, "no clear when disarmed", pcv, 8'h00);
      do_wr(1'b0, 8'h0C);
      do_rd(1'b0, 8'h00, 1'b0, 3'd0, rdv, pcv);
      chk(13, "poll empty", rdv, 8'h07);
      chk(13, "poll empty clear", pcv, 8'h00);

      // R6: special mask load is gated by its enable bit
      do_wr(1'b0, 8'h68);
      chk(6, "special mask set", {7'b0, smask_o}, 8'h01);
      do_wr(1'b0, 8'h28);
      chk(6, "special mask held", {7'b0, smask_o}, 8'h01);
      do_wr(1'b0, 8'h48);
      chk(6, "special mask cleared", {7'b0, smask_o}, 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule